// File: doc/BRIEF.md
# Clock Frequency Calibration Unit

This block measures how fast a quick clock runs against one of two slow reference clocks. Software loads a window length, counted in reference periods, into a duration register and sets a start bit. From then on a down-counting window timer steps once per rising edge of the chosen reference. A measurement counter counts every fast-clock cycle of the window, starting from zero. When the window timer runs out, the measurement stops, the start bit clears by itself, and a sticky done flag is raised. The done flag can also drive an interrupt.

Both reference inputs are asynchronous to the fast clock. Each one passes through a two-flop synchroniser and a rising-edge detector in the fast domain. The ratio of the result to the window length gives the fast-clock frequency in units of the reference frequency. A change of reference is held back until the reference currently in use has shown three rising edges, so a dead reference never takes part in a switch.

Register port: `addr` 0 is the control register, `addr` 1 the duration, `addr` 2 the low 16 bits of the result and `addr` 3 the result bits above 15. A write happens when `wr_en` is high at a clock edge. `rdata` follows `addr` combinationally.

Top module: `clk_cal_unit`

## Requirements
- R1: After reset the control register reads 0x0000, the duration reads 0x8000, both result words read 0 and `irq` is 0.
- R2: Writing control bit 0 (start) as 1 while idle loads the window timer from the duration and clears the measurement counter. From the next cycle bit 0 reads 1. The counter adds one for every fast clock in which bit 0 is 1, so the final result equals the number of cycles bit 0 read 1.
- R3: The window timer decreases by one for each synchronised rising edge of the active reference. The edge that finds the timer at 1 ends the measurement; a duration of 0 ends at the first edge. When the measurement ends, bit 0 reads 0 and control bit 3 (done) reads 1.
- R4: A control write with bit 0 as 0 during a measurement stops it at the next edge, leaves done at 0, and freezes the result.
- R5: If that stop write lands in the same cycle as the ending reference edge, done still becomes 1. This holds even when the same write carries bit 3 as 0.
- R6: A control write with bit 0 as 1 during a measurement neither restarts the counter nor reloads the timer.
- R7: Done stays 1 through later measurements. Only a control write with bit 3 as 0 clears it. Writing bit 3 as 1 leaves it unchanged.
- R8: `irq` is 1 exactly when done is 1 and control bit 2 (interrupt enable) is 1.
- R9: Control bit 1 selects the reference: 0 for `ref_a_i`, 1 for `ref_b_i`. A new selection takes effect only after the active reference has produced 3 rising edges since it became active (or since reset). Until then the old reference keeps clocking the timer.
- R10: The measurement counter stops at all ones instead of wrapping. It keeps its value after a measurement ends or is stopped, until the next start.
- R11: Writes to the duration register (`addr` 1) are ignored while bit 0 reads 1.
- R12: Control bits 15..4 read 0. Writes to them, including reserved bit 4, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock under measurement |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_a_i | input | 1 | Slow reference 0, asynchronous |
| ref_b_i | input | 1 | Slow reference 1, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| irq | output | 1 | Completion interrupt |

## Verification
The two functions that can meet in one cycle are the window ending in hardware and a software stop, and beside them the hardware setting done while the same write clears it. The bench drives a reference pulse with a known phase to the fast clock, so the edge that ends the window reaches the timer a known three edges after the input rises. It places the stop write, which carries done as 0, at exactly that edge. The result is judged by reading done as 1 and start as 0 afterwards. A separate stop, well away from any edge, must leave done at 0.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_DUR    = 2'd1;
    localparam logic [1:0] ADDR_RES_LO = 2'd2;
    localparam logic [1:0] ADDR_RES_HI = 2'd3;

    localparam int START_BIT = 0;
    localparam int SEL_BIT   = 1;
    localparam int IE_BIT    = 2;
    localparam int DONE_BIT  = 3;

    localparam int NUM_REFS = 2;

    typedef enum logic {
        REF_A = 1'b0,
        REF_B = 1'b1
    } ref_sel_e;
endpackage

// File: rtl/ccu_edge_sync.sv
module ccu_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int LAST = STAGES;

    // sh_q[0..STAGES-1] form the synchroniser, sh_q[STAGES] is the history bit
    logic [LAST:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LAST-1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[LAST-1] & ~sh_q[LAST];
endmodule

// File: rtl/ccu_ref_guard.sv
module ccu_ref_guard
    import ccu_pkg::*;
#(
    parameter int MIN_EDGES = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  ref_sel_e req_sel_i,
    input  logic     edge_a_i,
    input  logic     edge_b_i,
    output logic     tick_o,
    output ref_sel_e act_sel_o
);
    localparam int CW = $clog2(MIN_EDGES + 1);

    typedef struct packed {
        ref_sel_e        act;
        logic [CW-1:0]   seen;
    } guard_t;

    guard_t g_d, g_q;
    logic   tick;

    always_comb begin
        g_d  = g_q;
        tick = (g_q.act == REF_B) ? edge_b_i : edge_a_i;
        if (tick && (g_q.seen < CW'(MIN_EDGES)))
            g_d.seen = g_q.seen + 1'b1;
        if ((req_sel_i != g_q.act) && (g_q.seen == CW'(MIN_EDGES))) begin
            g_d.act  = req_sel_i;
            g_d.seen = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{act: REF_A, seen: '0};
        else        g_q <= g_d;
    end

    assign tick_o    = tick;
    assign act_sel_o = g_q.act;
endmodule

// File: rtl/clk_cal_unit.sv
module clk_cal_unit
    import ccu_pkg::*;
#(
    parameter int          DUR_W       = 16,
    parameter int          CNT_W       = 24,
    parameter logic [15:0] DUR_RST     = 16'h8000,
    parameter int          SYNC_STAGES = 2,
    parameter int          SWITCH_EDGES = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_a_i,
    input  logic        ref_b_i,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        irq
);
    localparam int RES_W = 32;

    typedef struct packed {
        logic             run;
        logic             sel;
        logic             ie;
        logic             done;
        logic [DUR_W-1:0] dur;
        logic [DUR_W-1:0] tmr;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    // reference synchronisers, one per slow input
    logic [NUM_REFS-1:0] refs_raw;
    logic [NUM_REFS-1:0] refs_rise;
    assign refs_raw = {ref_b_i, ref_a_i};

    for (genvar gi = 0; gi < NUM_REFS; gi++) begin : g_sync
        ccu_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (refs_raw[gi]),
            .rise_o  (refs_rise[gi])
        );
    end

    logic     tick;
    ref_sel_e act_sel;

    ccu_ref_guard #(.MIN_EDGES(SWITCH_EDGES)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_sel_i (ref_sel_e'(st_q.sel)),
        .edge_a_i  (refs_rise[0]),
        .edge_b_i  (refs_rise[1]),
        .tick_o    (tick),
        .act_sel_o (act_sel)
    );

    logic ctrl_wr, dur_wr, hw_end;

    always_comb begin
        st_d    = st_q;
        ctrl_wr = wr_en && (addr == ADDR_CTRL);
        dur_wr  = wr_en && (addr == ADDR_DUR) && !st_q.run;
        hw_end  = st_q.run && tick && (st_q.tmr <= DUR_W'(1));

        if (st_q.run) begin
            if (st_q.cnt != '1) st_d.cnt = st_q.cnt + 1'b1;
            if (tick)           st_d.tmr = st_q.tmr - 1'b1;
        end

        if (dur_wr) st_d.dur = wdata[DUR_W-1:0];

        if (ctrl_wr) begin
            st_d.sel = wdata[SEL_BIT];
            st_d.ie  = wdata[IE_BIT];
            if (!wdata[DONE_BIT]) st_d.done = 1'b0;
            if (wdata[START_BIT] && !st_q.run) begin
                st_d.run = 1'b1;
                st_d.tmr = st_q.dur;
                st_d.cnt = '0;
            end else if (!wdata[START_BIT] && st_q.run) begin
                st_d.run = 1'b0;
            end
        end

        // hardware completion overrides any software action in the same cycle
        if (hw_end) begin
            st_d.run  = 1'b0;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.dur  <= DUR_RST[DUR_W-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    logic [RES_W-1:0] res_ext;

    always_comb begin
        res_ext            = '0;
        res_ext[CNT_W-1:0] = st_q.cnt;
        rdata              = '0;
        unique case (addr)
            ADDR_CTRL: begin
                rdata[START_BIT] = st_q.run;
                rdata[SEL_BIT]   = st_q.sel;
                rdata[IE_BIT]    = st_q.ie;
                rdata[DONE_BIT]  = st_q.done;
            end
            ADDR_DUR:    rdata[DUR_W-1:0] = st_q.dur;
            ADDR_RES_LO: rdata = res_ext[15:0];
            default:     rdata = res_ext[31:16];
        endcase
    end

    assign irq = st_q.done & st_q.ie;

    // plain views of the state for the bound checker
    logic             run_w, done_w;
    logic [CNT_W-1:0] cnt_w;
    logic [DUR_W-1:0] dur_w;
    assign run_w  = st_q.run;
    assign done_w = st_q.done;
    assign cnt_w  = st_q.cnt;
    assign dur_w  = st_q.dur;
endmodule

// File: rtl/ccu_checker.sv
module ccu_checker #(
    parameter int DUR_W = 16,
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [15:0]      wdata,
    input logic             run,
    input logic             done,
    input logic [CNT_W-1:0] cnt,
    input logic [DUR_W-1:0] dur
);
    AST_END_CLEARS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(run)); // R3

    AST_SW_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && $past(wr_en) && ($past(addr) == 2'd0) && !$past(wdata[0])) |-> !run); // R4

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> ((cnt == $past(cnt) + 1'b1) || ($past(cnt) == '1 && cnt == '1))); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done) && !($past(wr_en) && ($past(addr) == 2'd0) && !$past(wdata[3]))) |-> done); // R7

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run) && !run) |-> $stable(cnt)); // R10

    AST_DUR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> $stable(dur)); // R11
endmodule

bind clk_cal_unit ccu_checker #(.DUR_W(DUR_W), .CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .run   (run_w),
    .done  (done_w),
    .cnt   (cnt_w),
    .dur   (dur_w)
);

// File: tb/clk_cal_unit_tb.sv
module clk_cal_unit_tb;
    localparam int TB_CNT_W = 12;
    localparam int HALF     = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_a = 1'b0, ref_b = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    always #10 clk = ~clk;

    clk_cal_unit #(.CNT_W(TB_CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_a_i(ref_a), .ref_b_i(ref_b),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    int total = 0;
    int bad   = 0;
    bit done_flag = 0;

    typedef struct {
        logic [1:0]  a;
        logic [15:0] exp;
        logic [15:0] mask;
        string       tag;
    } item_t;
    item_t sb_q[$];

    // automatic reference generator on ref_b
    bit auto_b = 0;
    always @(negedge clk) begin : gen_b
        int ph;
        if (auto_b) begin
            ph = ph + 1;
            if (ph >= HALF) begin ph = 0; ref_b <= ~ref_b; end
        end else ph = 0;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q[0];
                addr = it.a;
                #1;
                total++;
                if ((rdata & it.mask) != (it.exp & it.mask)) begin
                    bad++;
                    $display("FAIL %s actual=0x%04h expected=0x%04h", it.tag, rdata & it.mask, it.exp & it.mask);
                end
                void'(sb_q.pop_front());
            end
        end
    end

    task automatic expect_reg(input logic [1:0] a, input logic [15:0] e, input logic [15:0] m, input string tag);
        item_t it;
        it.a = a; it.exp = e; it.mask = m; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic flush();
        while (sb_q.size() > 0) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a; #1; v = rdata;
    endtask

    task automatic pulse_a();
        @(negedge clk); ref_a = 1'b1;
        repeat (3) @(negedge clk); ref_a = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_b();
        @(negedge clk); ref_b = 1'b1;
        repeat (3) @(negedge clk); ref_b = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // call right after wr() of a start: counts samples with start bit 1
    task automatic measure(output int n);
        n = 0;
        for (int k = 0; k < 20000; k++) begin
            addr = 2'd0; #1;
            if (!rdata[0]) break;
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, v2;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_reg(2'd0, 16'h0000, 16'hFFFF, "R1 ctrl");
        expect_reg(2'd1, 16'h8000, 16'hFFFF, "R1 dur");
        expect_reg(2'd2, 16'h0000, 16'hFFFF, "R1 res lo");
        expect_reg(2'd3, 16'h0000, 16'hFFFF, "R1 res hi");
        flush();
        chk(irq == 1'b0, "R1 irq", irq, 0);

        // R12 upper/reserved control bits
        wr(2'd0, 16'hFFF0);
        expect_reg(2'd0, 16'h0000, 16'hFFFF, "R12 reserved bits");
        flush();

        // R9 reference switch guard (ref_a idle so far)
        wr(2'd1, 16'd5);
        wr(2'd0, 16'h0003);
        repeat (3) pulse_b();
        rd(2'd0, v); chk(v[0] == 1'b1, "R9 ref_b ignored before switch", v[0], 1);
        repeat (3) pulse_a();
        rd(2'd0, v); chk(v[0] == 1'b1, "R9 ref_a still counting", v[0], 1);
        repeat (2) pulse_a();
        rd(2'd0, v); chk(v[0] == 1'b1, "R9 ref_a ignored after switch", v[0], 1);
        pulse_b();
        rd(2'd0, v); chk(v[0] == 1'b1, "R3 one tick left", v[0], 1);
        pulse_b();
        expect_reg(2'd0, 16'h000A, 16'hFFFF, "R3 end: start clear done set");
        flush();

        // R8 interrupt gating
        chk(irq == 1'b0, "R8 irq masked", irq, 0);
        wr(2'd0, 16'h000E); #1;
        chk(irq == 1'b1, "R8 irq enabled", irq, 1);
        wr(2'd0, 16'h0006); #1;
        chk(irq == 1'b0, "R8 irq after done clear", irq, 0);
        expect_reg(2'd0, 16'h0006, 16'hFFFF, "R7 done cleared by write");
        flush();
        wr(2'd0, 16'h0002);

        // R2 exact cycle count on ref_b
        auto_b = 1;
        wr(2'd1, 16'd6);
        wr(2'd0, 16'h0003);
        measure(n);
        rd(2'd2, v);
        chk(v == 16'(n), "R2 result equals running cycles", v, n);
        chk(n >= 40 && n <= 56, "R3 window length", n, 48);

        // R6/R7/R11 interventions during a run, done kept at 1
        wr(2'd0, 16'h000B);
        expect_reg(2'd0, 16'h0009, 16'h0009, "R7 done sticky while running");
        flush();
        repeat (15) @(negedge clk);
        wr(2'd0, 16'h000B);
        wr(2'd1, 16'h0100);
        n = 0;
        do begin rd(2'd0, v); n++; end while (v[0] && n < 1000);
        chk(v[3] == 1'b1, "R7 done still 1", v[3], 1);
        rd(2'd2, v);
        chk(v >= 16'd40 && v <= 16'd56, "R6 no restart", v, 48);
        expect_reg(2'd1, 16'd6, 16'hFFFF, "R11 duration write ignored");
        flush();

        // R4 software stop
        wr(2'd0, 16'h0002);
        wr(2'd0, 16'h0003);
        repeat (10) @(negedge clk);
        wr(2'd0, 16'h0002);
        expect_reg(2'd0, 16'h0002, 16'hFFFF, "R4 stopped, done 0");
        flush();
        rd(2'd2, v);
        chk(v >= 16'd10 && v <= 16'd14, "R4 partial count", v, 12);
        repeat (20) @(negedge clk);
        rd(2'd2, v2);
        chk(v2 == v, "R10 result held after stop", v2, v);

        // R5 collision of hardware end and software stop
        auto_b = 0;
        @(negedge clk); ref_b = 1'b0;
        repeat (10) @(negedge clk);
        wr(2'd1, 16'd2);
        wr(2'd0, 16'h0003);
        pulse_b();
        rd(2'd0, v); chk(v[0] == 1'b1, "R3 running after one tick", v[0], 1);
        @(negedge clk); ref_b = 1'b1;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = 16'h0002;
        @(negedge clk); wr_en = 1'b0;
        ref_b = 1'b0;
        expect_reg(2'd0, 16'h000A, 16'hFFFF, "R5 hardware end wins");
        flush();

        // R10 saturation
        wr(2'd0, 16'h0002);
        auto_b = 1;
        wr(2'd1, 16'd600);
        wr(2'd0, 16'h0003);
        measure(n);
        chk(n > 4095, "R10 window longer than range", n, 4096);
        expect_reg(2'd2, 16'h0FFF, 16'hFFFF, "R10 saturated low");
        expect_reg(2'd3, 16'h0000, 16'hFFFF, "R10 saturated high");
        flush();

        done_flag = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule